// File: doc/BRIEF.md
# Mask-Match Memory Bank Decoder

This block decides which of four logical memory banks owns a physical address. Each bank is described by one 64-bit decode word. The word holds a valid flag and two mask/match pairs. One pair covers a 12-bit upper slice of the address and the other covers a 4-bit lower slice. A bank claims an address when both slices equal its match values in every bit position that its mask does not exclude. If several banks claim the same address, the lowest-numbered one wins.

For the winning bank the block also works out three attributes: the interleave factor, coded in the lower mask; the bank base address; and the bank size. It also forms a global bank identifier from a controller port number supplied on an input. Decode words are written through a simple indexed write port. Address lookups are combinational up to one output register stage, so every result appears one clock after the address is sampled.

Top module: `mm_bank_decoder`

## Requirements
- R1: A bank whose valid flag is 0 never claims an address, whatever its other fields hold.
- R2: Upper check: the upper slice is address bits [41:30]. The check passes when (slice XOR upper match) has no 1 bit outside the positions set in the upper mask.
- R3: Lower check: the lower slice is address bits [9:6]. It is compared against the lower match under the lower mask by the same rule. A bank claims an address only when both checks pass.
- R4: When more than one bank claims an address, the reported bank is the lowest-numbered one, and all attributes come from that bank.
- R5: Interleave output from the lower mask: 4'hF gives 1, 4'hE gives 2, 4'hC gives 4, 4'h8 gives 8, and 4'h0 gives 16. Every other mask value gives 1.
- R6: Base output equals (upper match AND NOT upper mask) multiplied by 2^30.
- R7: Size output equals (upper mask bits [9:0] + 1) multiplied by 2^30, then divided by the interleave factor. Upper mask bits 10 and 11 have no effect on size.
- R8: The global identifier output equals 4 × port_id + bank index.
- R9: When no bank claims the address, hit is 0 and the bank index, identifier, interleave, base and size outputs are all 0.
- R10: Outputs are registered. A result reflects the address and the decode words present at the sampling clock edge and is visible after that edge. A write becomes effective at its clock edge and changes only the addressed bank.
- R11: Synchronous active-high reset clears the valid flag of every bank and drives all outputs to 0.
- R12: Decode word layout: valid at bit 63, upper mask at [52:41], upper match at [40:29], lower mask at [17:14], lower match at [12:9]. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a decode word |
| cfg_bank | input | 2 | Bank index written |
| cfg_word | input | 64 | Decode word value |
| port_id | input | 5 | Controller port number used for the global identifier |
| phys_addr | input | 42 | Physical address to look up |
| dec_hit | output | 1 | Some bank claims the address |
| dec_bank | output | 2 | Winning bank index |
| dec_gid | output | 7 | Global bank identifier |
| dec_ilv | output | 5 | Interleave factor (1, 2, 4, 8 or 16) |
| dec_base | output | 42 | Base address of the winning bank |
| dec_size | output | 42 | Size in bytes of the winning bank |

## Verification
The assertions assume that reset is held from time zero until the first clock edges, so that the bank state they sample through `$past` is defined. They also assume the address and decode-word inputs carry known values. The stimulus meets both assumptions. It holds reset for several cycles before any lookup. It drives every input to a defined value before reset is released. It changes inputs only on falling clock edges and keeps every write one full cycle ahead of the lookups that depend on it.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  // decode word geometry; the bit positions are what the writer encodes
  localparam int unsigned CFG_W          = 64;
  localparam int unsigned CFG_VALID_BIT  = 63;
  localparam int unsigned CFG_UMASK_LSB  = 41;
  localparam int unsigned CFG_UMATCH_LSB = 29;
  localparam int unsigned CFG_LMASK_LSB  = 14;
  localparam int unsigned CFG_LMATCH_LSB = 9;
endpackage

// File: rtl/bdec_cfg_store.sv
module bdec_cfg_store
  import bdec_pkg::*;
#(
  parameter int NB  = 4,
  parameter int UW  = 12,
  parameter int LW  = 4,
  parameter int BIW = $clog2(NB)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [BIW-1:0]          widx,
  input  logic [CFG_W-1:0]        wdata,
  output logic [NB-1:0]           valid,
  output logic [NB-1:0][UW-1:0]   umask,
  output logic [NB-1:0][UW-1:0]   umatch,
  output logic [NB-1:0][LW-1:0]   lmask,
  output logic [NB-1:0][LW-1:0]   lmatch
);
  // reserved bits of the word are dropped here
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        valid[g]  <= 1'b0;
        umask[g]  <= '0;
        umatch[g] <= '0;
        lmask[g]  <= '0;
        lmatch[g] <= '0;
      end else if (we && (widx == BIW'(g))) begin
        valid[g]  <= wdata[CFG_VALID_BIT];
        umask[g]  <= wdata[CFG_UMASK_LSB  +: UW];
        umatch[g] <= wdata[CFG_UMATCH_LSB +: UW];
        lmask[g]  <= wdata[CFG_LMASK_LSB  +: LW];
        lmatch[g] <= wdata[CFG_LMATCH_LSB +: LW];
      end
    end
  end
endmodule

// File: rtl/bdec_bank_cmp.sv
module bdec_bank_cmp #(
  parameter int UW = 12,
  parameter int LW = 4
) (
  input  logic          valid,
  input  logic [UW-1:0] umask,
  input  logic [UW-1:0] umatch,
  input  logic [LW-1:0] lmask,
  input  logic [LW-1:0] lmatch,
  input  logic [UW-1:0] ufield,
  input  logic [LW-1:0] lfield,
  output logic          hit
);
  logic [UW-1:0] udiff;
  logic [LW-1:0] ldiff;

  // differing bits that the mask does not excuse
  assign udiff = (ufield ^ umatch) & ~umask;
  assign ldiff = (lfield ^ lmatch) & ~lmask;
  assign hit   = valid && (udiff == '0) && (ldiff == '0);
endmodule

// File: rtl/bdec_prio.sv
module bdec_prio #(
  parameter int NB  = 4,
  parameter int BIW = $clog2(NB)
) (
  input  logic [NB-1:0]  req,
  output logic           any,
  output logic [BIW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (req[i]) idx = BIW'(i);
    end
  end
endmodule

// File: rtl/bdec_attr.sv
module bdec_attr #(
  parameter int UW    = 12,
  parameter int LW    = 4,
  parameter int UL    = 30,
  parameter int SZB   = 10,
  parameter int AW    = 42,
  parameter int ILV_W = LW + 1
) (
  input  logic [UW-1:0]    umask,
  input  logic [UW-1:0]    umatch,
  input  logic [LW-1:0]    lmask,
  output logic [ILV_W-1:0] ilv,
  output logic [AW-1:0]    base,
  output logic [AW-1:0]    size
);
  localparam int SHW = $clog2(LW + 1);

  logic [SHW-1:0] shamt;
  logic [SZB:0]   units;

  // a mask of ones followed by k zeros selects 2^k-way interleave
  always_comb begin
    logic [LW-1:0] pat;
    shamt = '0;
    for (int k = 1; k <= LW; k++) begin
      pat = {LW{1'b1}} << k;
      if (lmask == pat) shamt = SHW'(k);
    end
  end

  assign ilv   = ILV_W'(1) << shamt;
  assign base  = AW'(umatch & ~umask) << UL;
  assign units = {1'b0, umask[SZB-1:0]} + {{SZB{1'b0}}, 1'b1};
  assign size  = (AW'(units) << UL) >> shamt;
endmodule

// File: rtl/mm_bank_decoder.sv
module mm_bank_decoder
  import bdec_pkg::*;
#(
  parameter int NB    = 4,
  parameter int AW    = 42,
  parameter int UL    = 30,
  parameter int UW    = 12,
  parameter int LL    = 6,
  parameter int LW    = 4,
  parameter int SZB   = 10,
  parameter int PW    = 5,
  localparam int BIW   = $clog2(NB),
  localparam int ILV_W = LW + 1,
  localparam int GW    = PW + BIW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [BIW-1:0]   cfg_bank,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [PW-1:0]    port_id,
  input  logic [AW-1:0]    phys_addr,
  output logic             dec_hit,
  output logic [BIW-1:0]   dec_bank,
  output logic [GW-1:0]    dec_gid,
  output logic [ILV_W-1:0] dec_ilv,
  output logic [AW-1:0]    dec_base,
  output logic [AW-1:0]    dec_size
);
  logic [NB-1:0]         valid;
  logic [NB-1:0][UW-1:0] umask, umatch;
  logic [NB-1:0][LW-1:0] lmask, lmatch;
  logic [NB-1:0]         hit_vec;
  logic [UW-1:0]         ufield;
  logic [LW-1:0]         lfield;
  logic                  any_hit;
  logic [BIW-1:0]        sel;
  logic [ILV_W-1:0]      ilv_n;
  logic [AW-1:0]         base_n, size_n;
  logic [GW-1:0]         gid_n;
  logic                  unused_addr_bits;

  assign ufield           = phys_addr[UL +: UW];
  assign lfield           = phys_addr[LL +: LW];
  assign unused_addr_bits = ^phys_addr;

  bdec_cfg_store #(.NB(NB), .UW(UW), .LW(LW), .BIW(BIW)) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_bank), .wdata(cfg_word),
    .valid(valid), .umask(umask), .umatch(umatch), .lmask(lmask), .lmatch(lmatch)
  );

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    bdec_bank_cmp #(.UW(UW), .LW(LW)) u_cmp (
      .valid(valid[g]), .umask(umask[g]), .umatch(umatch[g]),
      .lmask(lmask[g]), .lmatch(lmatch[g]),
      .ufield(ufield), .lfield(lfield), .hit(hit_vec[g])
    );

    AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
      hit_vec[g] |-> valid[g]); // R1
  end

  bdec_prio #(.NB(NB), .BIW(BIW)) u_prio (
    .req(hit_vec), .any(any_hit), .idx(sel)
  );

  bdec_attr #(.UW(UW), .LW(LW), .UL(UL), .SZB(SZB), .AW(AW), .ILV_W(ILV_W)) u_attr (
    .umask(umask[sel]), .umatch(umatch[sel]), .lmask(lmask[sel]),
    .ilv(ilv_n), .base(base_n), .size(size_n)
  );

  assign gid_n = GW'(port_id) * GW'(NB) + GW'(sel);

  always_ff @(posedge clk) begin
    if (rst || !any_hit) begin
      dec_hit  <= 1'b0;
      dec_bank <= '0;
      dec_gid  <= '0;
      dec_ilv  <= '0;
      dec_base <= '0;
      dec_size <= '0;
    end else begin
      dec_hit  <= 1'b1;
      dec_bank <= sel;
      dec_gid  <= gid_n;
      dec_ilv  <= ilv_n;
      dec_base <= base_n;
      dec_size <= size_n;
    end
  end

  AST_FIRST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (((($past(hit_vec) >> dec_bank) & NB'(1)) == NB'(1)) &&
                 (($past(hit_vec) & ((NB'(1) << dec_bank) - NB'(1))) == '0))); // R4

  AST_ILV_POWER_OF_TWO: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> ($countones(dec_ilv) == 1)); // R5

  AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (dec_size != '0)); // R7

  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |-> (dec_bank == '0 && dec_gid == '0 && dec_ilv == '0 &&
                  dec_base == '0 && dec_size == '0)); // R9
endmodule

// File: tb/sim_mm_bank_decoder.sv
module sim_mm_bank_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_bank;
  logic [63:0] cfg_word;
  logic [4:0]  port_id;
  logic [41:0] phys_addr;
  logic        dec_hit;
  logic [1:0]  dec_bank;
  logic [6:0]  dec_gid;
  logic [4:0]  dec_ilv;
  logic [41:0] dec_base, dec_size;

  int unsigned seed = 32'h1234_5678;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [63:0] mw [4];

  always #5 clk = ~clk;

  mm_bank_decoder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_word(cfg_word),
    .port_id(port_id), .phys_addr(phys_addr), .dec_hit(dec_hit), .dec_bank(dec_bank),
    .dec_gid(dec_gid), .dec_ilv(dec_ilv), .dec_base(dec_base), .dec_size(dec_size)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[31:16], seed[15:0] ^ seed[31:16]};
  endfunction

  // decode word per R12, reserved bits filled with junk
  function automatic logic [63:0] mk(input logic v, input logic [11:0] uk, input logic [11:0] um,
                                     input logic [3:0] lk, input logic [3:0] lm);
    logic [31:0] j;
    j = rnd();
    return {v, j[9:0], uk, um, j[20:10], lk, j[21], lm, j[30:22]};
  endfunction

  function automatic logic [41:0] raddr();
    logic [31:0] a, b;
    a = rnd();
    b = rnd();
    return {a[9:0], b};
  endfunction

  task automatic model(input logic [41:0] a, output logic h, output logic [1:0] b,
                       output logic [6:0] gid, output logic [4:0] il,
                       output logic [41:0] bs, output logic [41:0] sz);
    logic [63:0] w;
    h = 1'b0; b = 2'd0; gid = 7'd0; il = 5'd0; bs = 42'd0; sz = 42'd0;
    for (int k = 3; k >= 0; k--) begin
      w = mw[k];
      if (w[63] && (((a[41:30] ^ w[40:29]) & ~w[52:41]) == 12'd0) &&
          (((a[9:6] ^ w[12:9]) & ~w[17:14]) == 4'd0)) begin
        h = 1'b1;
        b = 2'(k);
      end
    end
    if (h) begin
      w = mw[b];
      case (w[17:14])
        4'hF: il = 5'd1;
        4'hE: il = 5'd2;
        4'hC: il = 5'd4;
        4'h8: il = 5'd8;
        4'h0: il = 5'd16;
        default: il = 5'd1;
      endcase
      bs  = 42'(w[40:29] & ~w[52:41]) * 42'h4000_0000;
      sz  = ((42'(w[50:41]) + 42'd1) * 42'h4000_0000) / 42'(il);
      gid = 7'(port_id) * 7'd4 + 7'(b);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [63:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_word = w;
    mw[b] = w;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [41:0] a, input string tag);
    logic h; logic [1:0] b; logic [6:0] g; logic [4:0] il; logic [41:0] bs, sz;
    @(negedge clk);
    phys_addr = a;
    @(posedge clk);
    @(negedge clk);
    model(a, h, b, g, il, bs, sz);
    checks++;
    if (dec_hit !== h || dec_bank !== b || dec_gid !== g || dec_ilv !== il ||
        dec_base !== bs || dec_size !== sz) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%b bank=%0d gid=%0d ilv=%0d base=%h size=%h expected hit=%b bank=%0d gid=%0d ilv=%0d base=%h size=%h",
               tag, a, dec_hit, dec_bank, dec_gid, dec_ilv, dec_base, dec_size,
               h, b, g, il, bs, sz);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  lks [6];
    logic [11:0] uks [5];
    logic [11:0] uk, um;
    logic [3:0]  lk, lm;
    logic [41:0] a;
    logic [31:0] r;
    lks = '{4'hF, 4'hE, 4'hC, 4'h8, 4'h0, 4'h5};
    uks = '{12'h000, 12'h3FF, 12'hC00, 12'hFFF, 12'h155};
    rst = 1'b1; cfg_we = 1'b0; cfg_bank = 2'd0; cfg_word = 64'd0;
    port_id = 5'd5; phys_addr = 42'd0;
    for (int i = 0; i < 4; i++) mw[i] = 64'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state is all zero
    checks++;
    if (dec_hit !== 1'b0 || dec_bank !== 2'd0 || dec_ilv !== 5'd0 || dec_size !== 42'd0) begin
      errors++;
      $display("FAIL R11 reset outputs actual hit=%b ilv=%0d expected hit=0 ilv=0", dec_hit, dec_ilv);
    end
    rst = 1'b0;
    // R11: cleared banks claim nothing
    for (int i = 0; i < 8; i++) lookup(raddr(), "R11");

    // R3 R5 R12: exhaustive lower mask / match / field sweep
    for (int k = 0; k < 16; k++) begin
      for (int m = 0; m < 16; m++) begin
        r = rnd();
        wr(2'd0, mk(1'b1, 12'hFFF, r[11:0], 4'(k), 4'(m)));
        for (int f = 0; f < 16; f++) begin
          a = raddr();
          a[9:6] = 4'(f);
          lookup(a, "R3");
        end
      end
    end

    // R2 R6: upper compare with random masks and near-miss addresses
    for (int c = 0; c < 300; c++) begin
      r = rnd();
      uk = r[11:0] & r[23:12];
      um = r[31:20];
      wr(2'd0, mk(1'b1, uk, um, 4'hF, r[3:0]));
      for (int n = 0; n < 8; n++) begin
        r = rnd();
        a = raddr();
        a[41:30] = (n < 4) ? (um ^ (r[11:0] & uk)) : (um ^ r[11:0]);
        lookup(a, "R2,R6");
      end
    end

    // R7 R5: size from mask, high mask bits ignored
    for (int u = 0; u < 5; u++) begin
      for (int l = 0; l < 6; l++) begin
        wr(2'd0, mk(1'b1, uks[u], 12'h000, lks[l], 4'h0));
        for (int n = 0; n < 2; n++) begin
          r = rnd();
          a = raddr();
          a[41:30] = r[11:0] & uks[u];
          a[9:6] = r[15:12] & lks[l];
          lookup(a, "R7");
        end
      end
    end

    // R4 R10: overlapping banks, peel off from the lowest
    for (int b = 0; b < 4; b++) wr(2'(b), mk(1'b1, 12'hFF0, 12'h000, lks[4 - b], 4'h0));
    a = 42'd0;
    a[29:10] = 20'hABCDE;
    lookup(a, "R4");
    for (int b = 0; b < 4; b++) begin
      wr(2'(b), mk(1'b0, 12'hFF0, 12'h000, 4'h0, 4'h0));
      lookup(a, "R4");
      lookup(a, "R10");
    end

    // R1: invalid bank with fully permissive fields
    wr(2'd2, mk(1'b0, 12'hFFF, 12'h000, 4'h0, 4'h0));
    for (int i = 0; i < 4; i++) lookup(raddr(), "R1");

    // R8: identifier across port numbers
    wr(2'd3, mk(1'b1, 12'hFFF, 12'h000, 4'hC, 4'h0));
    for (int p = 0; p < 32; p += 31) begin
      @(negedge clk);
      port_id = 5'(p);
      lookup(raddr(), "R8");
    end
    port_id = 5'd9;

    // R10 R9: random configurations over all banks
    for (int s = 0; s < 100; s++) begin
      for (int b = 0; b < 4; b++) begin
        r = rnd();
        wr(2'(b), mk(r[31] | r[30], r[11:0] | 12'hF00, r[23:12], lks[r[26:24] % 6], r[29:26]));
      end
      for (int n = 0; n < 20; n++) begin
        r = rnd();
        a = raddr();
        if (r[0]) begin
          a[41:30] = mw[r[2:1]][40:29] ^ (r[14:3] & mw[r[2:1]][52:41]);
          a[9:6]   = mw[r[2:1]][12:9] ^ (r[18:15] & mw[r[2:1]][17:14]);
        end
        lookup(a, "R10");
        if (!r[0]) lookup(a, "R9");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule